// File: doc/BRIEF.md
# Host Bridge Register Window Decoder

This block sits on the CPU side of a host-to-PCI bridge. It decodes a 16 MB register window. Each request carries a byte address, byte enables and write data, and the block steers it to one of the targets below:

- the PCI I/O space stub;
- a configuration-address register held inside the block;
- the configuration-data byte window served by a configuration-cycle stub;
- an interrupt-acknowledge strobe towards the interrupt controller stub.

Any request that matches none of them reads as all ones, is dropped if it is a write, and raises a one-cycle flag.

The stubs share the request fields. They answer within the request cycle on their own read-data inputs. Every request gets a registered response one cycle later.

The block also watches configuration-data writes aimed at the bridge's own function, which is bus 0, device 0, function 0. A write to bridge register 0x40 captures a GPIO base. A write of the magic value 0x11 to register 0x44 maps the GPIO window at that base plus 0x38, or moves it there if it was already mapped.

Top module: `hbw_regwin_dec`

## Requirements
- R1: A write to the word at offset 0xc00cf8 updates the configuration-address register one byte per enabled lane. A read of that word returns the register. The register is always visible on cfg_addr_o.
- R2: A request to the word at 0xe00cfc raises cfg_req_o in the same cycle. cfg_lane_o gives the lowest enabled byte lane, and that lane equals the low two bits of the accessed byte address. A read there returns cfg_rdata_i.
- R3: A read of the word at 0xf00000 pulses iack_o in the request cycle and returns iack_vec_i in bits 7:0 with zeros above. A write there raises no strobe and is treated as undecoded.
- R4: A request to any other offset at or above 0xc00000 raises unmapped_o with the response. A read there returns 0xFFFFFFFF. A write there changes no register and reaches no stub.
- R5: Offsets below 0xc00000 go to the I/O stub through io_req_o, take priority over every other target, and return io_rdata_i on a read.
- R6: Every request gets exactly one response, with rsp_valid_o high in the cycle after it. No response appears without a request.
- R7: A configuration-data write captures the GPIO base from the enabled bytes when three conditions hold: cfg_addr_o bit 31 is set, bits 23:8 are zero, and {bits 7:2, lane} equals 0x40. Capturing the base does not change the mapping or gpio_addr_o.
- R8: A write under the same conditions at byte offset 0x44, whose enabled bytes form the value 0x11, sets gpio_map_o and loads gpio_addr_o with base + 0x38. Any other value, or the enable bit clear, leaves both unchanged. Once set, the mapping stays set.
- R9: After reset the configuration-address register is 0, the GPIO base is 0, gpio_map_o is 0, gpio_addr_o is 0, and no strobe or response is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present this cycle |
| req_write_i | input | 1 | 1 write, 0 read |
| req_addr_i | input | 24 | Byte offset in the window |
| req_be_i | input | 4 | Byte enables, lane k on data bits 8k+7:8k |
| req_wdata_i | input | 32 | Write data, lane aligned |
| rsp_valid_o | output | 1 | Response, one cycle after the request |
| rsp_rdata_o | output | 32 | Read data (zero for writes) |
| unmapped_o | output | 1 | Undecoded offset, with the response |
| io_req_o | output | 1 | Request goes to the I/O space stub |
| io_rdata_i | input | 32 | I/O stub read data |
| cfg_addr_o | output | 32 | Configuration-address register |
| cfg_req_o | output | 1 | Request goes to the configuration-data stub |
| cfg_lane_o | output | 2 | Starting byte lane in the data window |
| cfg_rdata_i | input | 32 | Configuration stub read data |
| iack_o | output | 1 | Interrupt-acknowledge strobe |
| iack_vec_i | input | 8 | Vector from the interrupt controller |
| gpio_map_o | output | 1 | GPIO window mapped |
| gpio_addr_o | output | 32 | GPIO window I/O address |

## Verification
A wrong configuration-address register shows up at once on cfg_addr_o and in the next read of its word. A wrong decode shows in the same cycle as a strobe on the wrong stub, and in the next cycle as wrong read data or a wrong unmapped_o. Errors in the captured GPIO base stay hidden until the next magic write, when gpio_addr_o comes out wrong. The bench therefore follows each base capture with magic writes, and also sends near-miss values and writes to non-bridge targets.

// File: rtl/hbw_pkg.sv
package hbw_pkg;
  typedef enum logic [2:0] {
    TGT_NONE  = 3'd0,
    TGT_IO    = 3'd1,
    TGT_CADDR = 3'd2,
    TGT_CDATA = 3'd3,
    TGT_IACK  = 3'd4
  } tgt_e;
endpackage

// File: rtl/hbw_decode.sv
module hbw_decode
  import hbw_pkg::*;
#(
  parameter int unsigned ADDR_W = 24,
  parameter int unsigned BE_W = 4,
  parameter logic [ADDR_W-1:0] IO_LIMIT = 24'hc00000,
  parameter logic [ADDR_W-1:0] CADDR_OFF = 24'hc00cf8,
  parameter logic [ADDR_W-1:0] CDATA_OFF = 24'he00cfc,
  parameter logic [ADDR_W-1:0] IACK_OFF = 24'hf00000,
  localparam int unsigned LANE_W = $clog2(BE_W)
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              write_i,
  input  logic [BE_W-1:0]   be_i,
  output tgt_e              tgt_o,
  output logic [LANE_W-1:0] lane_o
);
  logic [ADDR_W-LANE_W-1:0] word;
  assign word = addr_i[ADDR_W-1:LANE_W];

  always_comb begin
    lane_o = '0;
    for (int i = BE_W - 1; i >= 0; i--) begin
      if (be_i[i]) lane_o = LANE_W'(i);
    end
  end

  // I/O space overlays the window and wins
  always_comb begin
    if (addr_i < IO_LIMIT)                                       tgt_o = TGT_IO;
    else if (word == CADDR_OFF[ADDR_W-1:LANE_W])                 tgt_o = TGT_CADDR;
    else if (word == CDATA_OFF[ADDR_W-1:LANE_W])                 tgt_o = TGT_CDATA;
    else if (word == IACK_OFF[ADDR_W-1:LANE_W] && !write_i)      tgt_o = TGT_IACK;
    else                                                         tgt_o = TGT_NONE;
  end
endmodule

// File: rtl/hbw_cfg_hook.sv
module hbw_cfg_hook #(
  parameter int unsigned DATA_W = 32,
  parameter logic [7:0] BASE_REG = 8'h40,
  parameter logic [7:0] MAP_REG = 8'h44,
  parameter logic [DATA_W-1:0] MAGIC = 32'h11,
  parameter logic [DATA_W-1:0] GPIO_OFS = 32'h38,
  localparam int unsigned BE_W = DATA_W / 8,
  localparam int unsigned LANE_W = $clog2(BE_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] cfg_addr_i,
  input  logic [LANE_W-1:0] lane_i,
  input  logic [BE_W-1:0]   be_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              map_o,
  output logic [DATA_W-1:0] win_o
);
  logic [DATA_W-1:0] mask, val, base_q;
  logic [7:0]        off;
  logic              self_hit;
  logic              unused_bits;

  for (genvar g = 0; g < BE_W; g++) begin : g_mask
    assign mask[8*g +: 8] = {8{be_i[g]}};
  end

  assign val         = wdata_i & mask;
  assign off         = {cfg_addr_i[7:LANE_W], lane_i};
  assign self_hit    = cfg_addr_i[DATA_W-1] && (cfg_addr_i[23:8] == '0);
  assign unused_bits = ^cfg_addr_i[DATA_W-2:24];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q <= '0;
      map_o  <= 1'b0;
      win_o  <= '0;
    end else if (wr_i && self_hit) begin
      if (off == BASE_REG) base_q <= val;
      if (off == MAP_REG && val == MAGIC) begin
        map_o <= 1'b1;
        win_o <= base_q + GPIO_OFS;
      end
    end
  end
endmodule

// File: rtl/hbw_rsp.sv
module hbw_rsp
  import hbw_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned VEC_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic              write_i,
  input  tgt_e              tgt_i,
  input  logic [DATA_W-1:0] caddr_i,
  input  logic [DATA_W-1:0] cfg_rdata_i,
  input  logic [DATA_W-1:0] io_rdata_i,
  input  logic [VEC_W-1:0]  vec_i,
  output logic              valid_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              unmapped_o
);
  logic [DATA_W-1:0] rd_mux;

  always_comb begin
    unique case (tgt_i)
      TGT_IO:    rd_mux = io_rdata_i;
      TGT_CADDR: rd_mux = caddr_i;
      TGT_CDATA: rd_mux = cfg_rdata_i;
      TGT_IACK:  rd_mux = DATA_W'(vec_i);
      default:   rd_mux = '1;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o    <= 1'b0;
      rdata_o    <= '0;
      unmapped_o <= 1'b0;
    end else begin
      valid_o    <= valid_i;
      unmapped_o <= valid_i && (tgt_i == TGT_NONE);
      rdata_o    <= (valid_i && !write_i) ? rd_mux : '0;
    end
  end
endmodule

// File: rtl/hbw_regwin_dec.sv
module hbw_regwin_dec
  import hbw_pkg::*;
#(
  parameter int unsigned ADDR_W = 24,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned VEC_W = 8,
  parameter logic [ADDR_W-1:0] IO_LIMIT = 24'hc00000,
  parameter logic [ADDR_W-1:0] CADDR_OFF = 24'hc00cf8,
  parameter logic [ADDR_W-1:0] CDATA_OFF = 24'he00cfc,
  parameter logic [ADDR_W-1:0] IACK_OFF = 24'hf00000,
  parameter logic [7:0] BASE_REG = 8'h40,
  parameter logic [7:0] MAP_REG = 8'h44,
  parameter logic [DATA_W-1:0] MAGIC = 32'h11,
  parameter logic [DATA_W-1:0] GPIO_OFS = 32'h38,
  localparam int unsigned BE_W = DATA_W / 8,
  localparam int unsigned LANE_W = $clog2(BE_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic              req_write_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [BE_W-1:0]   req_be_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  output logic              rsp_valid_o,
  output logic [DATA_W-1:0] rsp_rdata_o,
  output logic              unmapped_o,
  output logic              io_req_o,
  input  logic [DATA_W-1:0] io_rdata_i,
  output logic [DATA_W-1:0] cfg_addr_o,
  output logic              cfg_req_o,
  output logic [LANE_W-1:0] cfg_lane_o,
  input  logic [DATA_W-1:0] cfg_rdata_i,
  output logic              iack_o,
  input  logic [VEC_W-1:0]  iack_vec_i,
  output logic              gpio_map_o,
  output logic [DATA_W-1:0] gpio_addr_o
);
  tgt_e tgt;
  logic caddr_wr;

  hbw_decode #(
    .ADDR_W(ADDR_W), .BE_W(BE_W), .IO_LIMIT(IO_LIMIT),
    .CADDR_OFF(CADDR_OFF), .CDATA_OFF(CDATA_OFF), .IACK_OFF(IACK_OFF)
  ) u_dec (
    .addr_i(req_addr_i), .write_i(req_write_i), .be_i(req_be_i),
    .tgt_o(tgt), .lane_o(cfg_lane_o)
  );

  assign io_req_o  = req_valid_i && (tgt == TGT_IO);
  assign cfg_req_o = req_valid_i && (tgt == TGT_CDATA);
  assign iack_o    = req_valid_i && (tgt == TGT_IACK);
  assign caddr_wr  = req_valid_i && req_write_i && (tgt == TGT_CADDR);

  for (genvar g = 0; g < BE_W; g++) begin : g_caddr
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                     cfg_addr_o[8*g +: 8] <= '0;
      else if (caddr_wr && req_be_i[g]) cfg_addr_o[8*g +: 8] <= req_wdata_i[8*g +: 8];
    end
  end

  hbw_cfg_hook #(
    .DATA_W(DATA_W), .BASE_REG(BASE_REG), .MAP_REG(MAP_REG),
    .MAGIC(MAGIC), .GPIO_OFS(GPIO_OFS)
  ) u_hook (
    .clk_i, .rst_ni,
    .wr_i(cfg_req_o && req_write_i),
    .cfg_addr_i(cfg_addr_o), .lane_i(cfg_lane_o), .be_i(req_be_i),
    .wdata_i(req_wdata_i), .map_o(gpio_map_o), .win_o(gpio_addr_o)
  );

  hbw_rsp #(.DATA_W(DATA_W), .VEC_W(VEC_W)) u_rsp (
    .clk_i, .rst_ni,
    .valid_i(req_valid_i), .write_i(req_write_i), .tgt_i(tgt),
    .caddr_i(cfg_addr_o), .cfg_rdata_i, .io_rdata_i, .vec_i(iack_vec_i),
    .valid_o(rsp_valid_o), .rdata_o(rsp_rdata_o), .unmapped_o
  );
endmodule

// File: rtl/hbw_regwin_chk.sv
module hbw_regwin_chk #(
  parameter int unsigned ADDR_W = 24,
  parameter int unsigned DATA_W = 32,
  parameter logic [ADDR_W-1:0] IO_LIMIT = 24'hc00000
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_valid_i,
  input logic              req_write_i,
  input logic [ADDR_W-1:0] req_addr_i,
  input logic              rsp_valid_o,
  input logic [DATA_W-1:0] rsp_rdata_o,
  input logic              unmapped_o,
  input logic              io_req_o,
  input logic              cfg_req_o,
  input logic              iack_o,
  input logic              gpio_map_o,
  input logic [DATA_W-1:0] gpio_addr_o
);
  a_r6_rsp_after_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> rsp_valid_o);
  a_r6_no_spurious_rsp: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> !rsp_valid_o);
  a_r3_iack_read_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    iack_o |-> (req_valid_i && !req_write_i));
  a_r2_single_target: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({io_req_o, cfg_req_o, iack_o}));
  a_r5_io_priority: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_addr_i < IO_LIMIT) |-> io_req_o);
  a_r4_unmapped_ones: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !req_write_i && !io_req_o && !cfg_req_o && !iack_o &&
     !(req_addr_i[ADDR_W-1:2] == 22'h30033e)) |=> (unmapped_o && rsp_rdata_o == '1));
  a_r4_unmapped_no_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    unmapped_o |-> $past(!io_req_o && !cfg_req_o && !iack_o));
  a_r8_map_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gpio_map_o |=> gpio_map_o);
  a_r8_win_moves_on_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(gpio_addr_o) |-> $past(cfg_req_o && req_write_i));
endmodule

bind hbw_regwin_dec hbw_regwin_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .IO_LIMIT(IO_LIMIT)
) chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_valid_i(req_valid_i),
  .req_write_i(req_write_i), .req_addr_i(req_addr_i),
  .rsp_valid_o(rsp_valid_o), .rsp_rdata_o(rsp_rdata_o),
  .unmapped_o(unmapped_o), .io_req_o(io_req_o), .cfg_req_o(cfg_req_o),
  .iack_o(iack_o), .gpio_map_o(gpio_map_o), .gpio_addr_o(gpio_addr_o)
);

// File: tb/hbw_regwin_dec_tb.sv
module hbw_regwin_dec_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_valid_i = 1'b0, req_write_i = 1'b0;
  logic [23:0] req_addr_i = '0;
  logic [3:0]  req_be_i = '0;
  logic [31:0] req_wdata_i = '0, io_rdata_i = '0, cfg_rdata_i = '0;
  logic [7:0]  iack_vec_i = '0;
  logic        rsp_valid_o, unmapped_o, io_req_o, cfg_req_o, iack_o, gpio_map_o;
  logic [31:0] rsp_rdata_o, cfg_addr_o, gpio_addr_o;
  logic [1:0]  cfg_lane_o;

  int errors = 0, checks = 0;
  logic [31:0] m_caddr = '0, m_base = '0, m_win = '0;
  logic        m_map = 1'b0;

  always #10 clk_i = ~clk_i;

  hbw_regwin_dec dut_i (.*);

  // target codes: 0 none, 1 io, 2 caddr, 3 cdata, 4 iack
  function automatic int exp_tgt(input logic [23:0] a, input logic w);
    if (a < 24'hc00000) return 1;
    if (a[23:2] == 22'h300_33e) return 2;
    if (a[23:2] == 22'h380_33f) return 3;
    if (a[23:2] == 22'h3c0_000 && !w) return 4;
    return 0;
  endfunction

  function automatic logic [1:0] low_lane(input logic [3:0] be);
    for (int i = 0; i < 4; i++) if (be[i]) return 2'(i);
    return 2'd0;
  endfunction

  function automatic logic [31:0] be_mask(input logic [3:0] be);
    logic [31:0] m;
    for (int i = 0; i < 4; i++) m[8*i +: 8] = {8{be[i]}};
    return m;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic access(input logic w, input logic [23:0] a, input logic [3:0] be,
                        input logic [31:0] d);
    int t;
    logic [31:0] exp_rd, v;
    logic [7:0]  off;
    t = exp_tgt(a, w);
    req_valid_i = 1'b1; req_write_i = w; req_addr_i = a; req_be_i = be;
    req_wdata_i = d;
    io_rdata_i = $urandom; cfg_rdata_i = $urandom; iack_vec_i = 8'($urandom);
    #2;
    chk("R5 io_req", 32'(io_req_o), 32'(t == 1));
    chk("R2 cfg_req", 32'(cfg_req_o), 32'(t == 3));
    if (t == 3) chk("R2 lane", 32'(cfg_lane_o), 32'(low_lane(be)));
    chk("R3 iack", 32'(iack_o), 32'(t == 4));
    case (t)
      1: exp_rd = io_rdata_i;
      2: exp_rd = m_caddr;
      3: exp_rd = cfg_rdata_i;
      4: exp_rd = {24'h0, iack_vec_i};
      default: exp_rd = 32'hFFFF_FFFF;
    endcase
    // model update
    if (w && t == 2) m_caddr = (m_caddr & ~be_mask(be)) | (d & be_mask(be));
    if (w && t == 3 && m_caddr[31] && m_caddr[23:8] == 16'h0) begin
      off = {m_caddr[7:2], low_lane(be)};
      v = d & be_mask(be);
      if (off == 8'h40) m_base = v;
      else if (off == 8'h44 && v == 32'h11) begin m_map = 1'b1; m_win = m_base + 32'h38; end
    end
    @(negedge clk_i);
    chk("R6 rsp_valid", 32'(rsp_valid_o), 32'd1);
    chk("R4 unmapped", 32'(unmapped_o), 32'(t == 0));
    if (!w) chk(t == 0 ? "R4 rdata" : "R1/R2/R3/R5 rdata", rsp_rdata_o, exp_rd);
    chk("R1 cfg_addr", cfg_addr_o, m_caddr);
    chk("R8 gpio_map", 32'(gpio_map_o), 32'(m_map));
    chk("R7/R8 gpio_addr", gpio_addr_o, m_win);
    req_valid_i = 1'b0;
  endtask

  initial begin
    #(20 * 150000);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk_i);
    // R9 reset state
    chk("R9 cfg_addr", cfg_addr_o, 32'h0);
    chk("R9 map", 32'(gpio_map_o), 32'h0);
    chk("R9 gpio_addr", gpio_addr_o, 32'h0);
    chk("R9 rsp_valid", 32'(rsp_valid_o), 32'h0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R6 idle", 32'(rsp_valid_o), 32'h0);

    // R9: magic before any base write maps at 0 + 0x38
    access(1, 24'hc00cf8, 4'hf, 32'h8000_0044);
    access(1, 24'he00cfc, 4'h1, 32'h11);
    // R7 base capture, R8 near misses and remap
    access(1, 24'hc00cf8, 4'hf, 32'h8000_0040);
    access(1, 24'he00cfc, 4'hf, 32'h0000_1000);
    access(1, 24'hc00cf8, 4'h1, 32'h0000_0044);
    access(1, 24'he00cfd, 4'h2, 32'h0000_1100);  // lane 1 -> offset 0x45
    access(1, 24'he00cfc, 4'h1, 32'h12);
    access(1, 24'he00cfc, 4'hf, 32'h0000_0111);
    access(1, 24'he00cfc, 4'h3, 32'h0000_0011);
    access(1, 24'hc00cf8, 4'h8, 32'h0000_0000);  // clear enable bit
    access(1, 24'he00cfc, 4'h1, 32'h11);
    access(1, 24'hc00cf8, 4'hf, 32'h8000_0840);  // device 1
    access(1, 24'he00cfc, 4'hf, 32'h0000_5000);
    access(1, 24'hc00cf8, 4'hf, 32'h8000_0040);
    access(1, 24'he00cfc, 4'hf, 32'h0000_2000);
    access(1, 24'hc00cf8, 4'h1, 32'h0000_0044);
    access(1, 24'he00cfc, 4'h1, 32'h11);
    // R3 write to iack is undecoded, R4 writes dropped
    access(1, 24'hf00000, 4'h1, 32'hAA);
    access(1, 24'hd12344, 4'hf, 32'hDEAD_BEEF);
    access(0, 24'hd12344, 4'hf, 32'h0);
    access(0, 24'hffffff, 4'h8, 32'h0);
    access(0, 24'hc00000, 4'h1, 32'h0);
    access(0, 24'hbfffff, 4'h8, 32'h0);
    access(0, 24'hf00000, 4'h1, 32'h0);
    access(0, 24'hc00cf8, 4'hf, 32'h0);

    for (int n = 0; n < 600; n++) begin
      logic [23:0] a;
      logic [31:0] d;
      logic [3:0]  be;
      int cls;
      cls = $urandom_range(0, 5);
      be = 4'($urandom_range(1, 15));
      d = $urandom;
      case (cls)
        0: a = 24'($urandom_range(0, 24'hbfffff));
        1: begin
          a = 24'hc00cf8 | 24'($urandom_range(0, 3));
          case ($urandom_range(0, 3))
            0: d = 32'h8000_0040;
            1: d = 32'h8000_0044;
            2: d = 32'h0000_0044;
            default: ;
          endcase
        end
        2, 3: begin
          a = 24'he00cfc | 24'($urandom_range(0, 3));
          if ($urandom_range(0, 1) == 1) d = 32'h11;
        end
        4: a = 24'hf00000 | 24'($urandom_range(0, 3));
        default: a = 24'($urandom_range(24'hc00000, 24'hffffff));
      endcase
      access(1'($urandom_range(0, 1)), a, be, d);
    end
    @(negedge clk_i);
    chk("R6 no trailing rsp", 32'(rsp_valid_o), 32'h0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule